// File: doc/BRIEF.md
# Protected RTC Register Front End

This block is the bus-facing register layer placed in front of a real-time-clock counting core. Software writes land in shadow copies. The live copies, which drive the core, change only when software writes the trigger register. A fixed-length commit then runs, and a busy flag is visible for its whole length. At the edge where the commit finishes, every shadow word eligible for update is copied to its live copy in a single step.

Three guards protect the live state:
- A key byte in the upper half of any control-word write. Without it the write does nothing.
- Two power-key words. These put the core into normal operation, but only after the configuration words have already been committed with their init values.
- A two-step unlock sequence on the protection register, with each step needing its own completed commit.

Until the unlock sequence completes, writes to the time, alarm and interrupt-enable words are dropped.

Top module: `rtc_regif`

## Requirements
- R1: A shadow write leaves the live outputs unchanged until a commit completes. At the completing edge every shadow word is copied to its live copy. A shadow write in that same cycle does not reach live state and waits for the next commit.
- R2: Writing a value with bit 0 set to offset 0x78 starts a commit. While the commit runs, `busy_o` and bit 6 of the control word (0x00) read 1, for exactly 4 cycles. Live values update at the edge where busy clears. A trigger written while busy is already high is ignored and does not lengthen the commit.
- R3: A write to the control word (0x00) has an effect only when bits 15:8 equal 0x43. With the key present, bit 5 gives a one-cycle pulse on `reload_o`, and bit 4 clears both power-key words (shadow and live) and clears time-valid.
- R4: The interface unlocks only after 0x9136 and then 0x586A have been written to offset 0x70, with a commit completed after each write. Once unlocked it stays unlocked. The unlocked state shows on `unlocked_o` and on control bit 3.
- R5: A wrong value, or the correct values in the wrong order, reaching the protection register through a commit returns the unlock sequence to its first step.
- R6: While locked, writes to the time words (0x20 to 0x34, step 4), the alarm words (0x80 to 0x94, step 4) and interrupt enable (0x08) are dropped. Reads of these words always return their current shadow values.
- R7: The power keys at 0x4C and 0x50 are committed to live state only when the live configuration words at 0x5C and 0x60 already hold 0x4848 and 0x0048 from an earlier commit. Normal operation (`core_run_o`, control bit 0) requires live keys 0xA357 and 0x67D2.
- R8: `pwr_lost_o` and control bit 1 are high whenever the live power keys do not match, including right after reset.
- R9: Time-valid (`time_valid_o`, control bit 2) is clear after reset. It is set by the first completed commit that carries at least one accepted time-word write.
- R10: After reset all shadow and live words are zero, the block is idle and locked, and the control word reads 0x0002. Control bits 5 and 4, the trigger register and the protection register all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, same cycle, zero when not reading |
| live_time_o | output | N_TIME*DATA_W | Live time words, word k at bits k*DATA_W |
| live_alarm_o | output | N_ALARM*DATA_W | Live alarm words |
| live_irq_en_o | output | DATA_W | Live interrupt enable word |
| busy_o | output | 1 | Commit in progress |
| unlocked_o | output | 1 | Unlock sequence complete |
| core_run_o | output | 1 | Power keys and configuration valid |
| pwr_lost_o | output | 1 | Live power keys mismatch |
| time_valid_o | output | 1 | Time has been written and committed |
| reload_o | output | 1 | One-cycle reload request |

## Verification
A shadow write and the completion of a commit can fall on the same clock edge. In that case the live copy must take the old shadow value, while the shadow register takes the new one and keeps it pending.

The bench provokes this by driving a time-word write in the fourth cycle after a trigger. It then judges the result at the ports:
- the live output still shows the previous value;
- a bus read returns the new value;
- a further commit moves the new value to the live output.

A second trigger issued during busy is also placed inside a running commit, and the busy length is timed cycle by cycle.

// File: rtl/rtc_regif_pkg.sv
package rtc_regif_pkg;
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_IRQ_EN = 'h08;
  localparam int unsigned OFS_TIME0  = 'h20;
  localparam int unsigned OFS_PK_A   = 'h4C;
  localparam int unsigned OFS_PK_B   = 'h50;
  localparam int unsigned OFS_CFG_A  = 'h5C;
  localparam int unsigned OFS_CFG_B  = 'h60;
  localparam int unsigned OFS_PROT   = 'h70;
  localparam int unsigned OFS_TRIG   = 'h78;
  localparam int unsigned OFS_ALM0   = 'h80;

  localparam logic [7:0]  CTRL_KEY   = 8'h43;
  localparam logic [15:0] PK_A_VAL   = 16'hA357;
  localparam logic [15:0] PK_B_VAL   = 16'h67D2;
  localparam logic [15:0] CFG_A_VAL  = 16'h4848;
  localparam logic [15:0] CFG_B_VAL  = 16'h0048;
  localparam logic [15:0] UNLOCK_A   = 16'h9136;
  localparam logic [15:0] UNLOCK_B   = 16'h586A;

  localparam int unsigned BIT_RUN    = 0;
  localparam int unsigned BIT_LOST   = 1;
  localparam int unsigned BIT_VALID  = 2;
  localparam int unsigned BIT_OPEN   = 3;
  localparam int unsigned BIT_CLRKEY = 4;
  localparam int unsigned BIT_RELOAD = 5;
  localparam int unsigned BIT_BUSY   = 6;

  // sys bank word order
  localparam int unsigned SYS_CFG_A = 0;
  localparam int unsigned SYS_CFG_B = 1;
  localparam int unsigned SYS_PK_A  = 2;
  localparam int unsigned SYS_PK_B  = 3;
  localparam int unsigned SYS_WORDS = 4;

  typedef enum logic [1:0] {
    UL_WAIT_A = 2'd0,
    UL_WAIT_B = 2'd1,
    UL_OPEN   = 2'd2
  } unlock_st_e;
endpackage

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank #(
  parameter int unsigned N_WORDS = 1,
  parameter int unsigned WORD_W  = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [N_WORDS-1:0]               wr_i,
  input  logic [N_WORDS-1:0]               commit_i,
  input  logic [N_WORDS-1:0]               clr_i,
  input  logic [WORD_W-1:0]                wdata_i,
  output logic [N_WORDS-1:0][WORD_W-1:0]   shadow_o,
  output logic [N_WORDS-1:0][WORD_W-1:0]   live_o
);
  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] sh_q, lv_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        sh_q <= '0;
      else if (clr_i[g])  sh_q <= '0;
      else if (wr_i[g])   sh_q <= wdata_i;
    end

    // live takes the pre-edge shadow value
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          lv_q <= '0;
      else if (clr_i[g])    lv_q <= '0;
      else if (commit_i[g]) lv_q <= sh_q;
    end

    assign shadow_o[g] = sh_q;
    assign live_o[g]   = lv_q;
  end
endmodule

// File: rtl/rtc_commit_ctrl.sv
module rtc_commit_ctrl #(
  parameter int unsigned COMMIT_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (COMMIT_CYC > 1) ? $clog2(COMMIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COMMIT_CYC - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (trig_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == CNT_LAST) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == CNT_LAST);
endmodule

// File: rtl/rtc_unlock_seq.sv
module rtc_unlock_seq
  import rtc_regif_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              open_o
);
  unlock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (done_i && pend_i) begin
      unique case (st_q)
        UL_WAIT_A: st_d = (val_i == DATA_W'(UNLOCK_A)) ? UL_WAIT_B : UL_WAIT_A;
        UL_WAIT_B: st_d = (val_i == DATA_W'(UNLOCK_B)) ? UL_OPEN   : UL_WAIT_A;
        default:   st_d = UL_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= UL_WAIT_A;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == UL_OPEN);
endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_regif_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned N_TIME     = 6,
  parameter int unsigned N_ALARM    = 6,
  parameter int unsigned COMMIT_CYC = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [DATA_W-1:0]           rdata_o,
  output logic [N_TIME*DATA_W-1:0]    live_time_o,
  output logic [N_ALARM*DATA_W-1:0]   live_alarm_o,
  output logic [DATA_W-1:0]           live_irq_en_o,
  output logic                        busy_o,
  output logic                        unlocked_o,
  output logic                        core_run_o,
  output logic                        pwr_lost_o,
  output logic                        time_valid_o,
  output logic                        reload_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_IRQ  = ADDR_W'(OFS_IRQ_EN);
  localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(OFS_PROT);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(OFS_TRIG);

  logic bus_wr, bus_rd, open, done, trig, ctrl_ok, clr_cmd;
  assign bus_wr  = req_i && we_i;
  assign bus_rd  = req_i && !we_i;
  assign trig    = bus_wr && (addr_i == A_TRIG) && wdata_i[0];
  assign ctrl_ok = bus_wr && (addr_i == A_CTRL) && (wdata_i[DATA_W-1:DATA_W-8] == CTRL_KEY);
  assign clr_cmd = ctrl_ok && wdata_i[BIT_CLRKEY];

  // decode
  logic [N_TIME-1:0]    time_hit;
  logic [N_ALARM-1:0]   alm_hit;
  logic [SYS_WORDS-1:0] sys_hit;
  for (genvar k = 0; k < N_TIME; k++) begin : g_thit
    assign time_hit[k] = (addr_i == ADDR_W'(OFS_TIME0 + 4 * k));
  end
  for (genvar k = 0; k < N_ALARM; k++) begin : g_ahit
    assign alm_hit[k] = (addr_i == ADDR_W'(OFS_ALM0 + 4 * k));
  end
  assign sys_hit[SYS_CFG_A] = (addr_i == ADDR_W'(OFS_CFG_A));
  assign sys_hit[SYS_CFG_B] = (addr_i == ADDR_W'(OFS_CFG_B));
  assign sys_hit[SYS_PK_A]  = (addr_i == ADDR_W'(OFS_PK_A));
  assign sys_hit[SYS_PK_B]  = (addr_i == ADDR_W'(OFS_PK_B));

  logic guarded_wr;
  assign guarded_wr = bus_wr && open;

  logic [N_TIME-1:0]  time_wr;
  logic [N_ALARM-1:0] alm_wr;
  logic               irq_wr;
  assign time_wr = {N_TIME{guarded_wr}} & time_hit;
  assign alm_wr  = {N_ALARM{guarded_wr}} & alm_hit;
  assign irq_wr  = guarded_wr && (addr_i == A_IRQ);

  // commit sequencer
  rtc_commit_ctrl #(.COMMIT_CYC(COMMIT_CYC)) u_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trig_i (trig),
    .busy_o (busy_o),
    .done_o (done)
  );

  // banks
  logic [N_TIME-1:0][DATA_W-1:0]    time_sh, time_lv;
  logic [N_ALARM-1:0][DATA_W-1:0]   alm_sh, alm_lv;
  logic [0:0][DATA_W-1:0]           irq_sh, irq_lv;
  logic [SYS_WORDS-1:0][DATA_W-1:0] sys_sh, sys_lv;

  rtc_shadow_bank #(.N_WORDS(N_TIME), .WORD_W(DATA_W)) u_time (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (time_wr),
    .commit_i ({N_TIME{done}}), .clr_i ('0), .wdata_i (wdata_i),
    .shadow_o (time_sh), .live_o (time_lv)
  );

  rtc_shadow_bank #(.N_WORDS(N_ALARM), .WORD_W(DATA_W)) u_alarm (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (alm_wr),
    .commit_i ({N_ALARM{done}}), .clr_i ('0), .wdata_i (wdata_i),
    .shadow_o (alm_sh), .live_o (alm_lv)
  );

  rtc_shadow_bank #(.N_WORDS(1), .WORD_W(DATA_W)) u_irq (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i (irq_wr),
    .commit_i (done), .clr_i (1'b0), .wdata_i (wdata_i),
    .shadow_o (irq_sh), .live_o (irq_lv)
  );

  // configuration must already be live before keys are taken
  logic cfg_ready, key_ok;
  assign cfg_ready = (sys_lv[SYS_CFG_A] == DATA_W'(CFG_A_VAL)) &&
                     (sys_lv[SYS_CFG_B] == DATA_W'(CFG_B_VAL));
  assign key_ok    = (sys_lv[SYS_PK_A] == DATA_W'(PK_A_VAL)) &&
                     (sys_lv[SYS_PK_B] == DATA_W'(PK_B_VAL));

  logic [SYS_WORDS-1:0] sys_commit, sys_clr;
  assign sys_commit[SYS_CFG_A] = done;
  assign sys_commit[SYS_CFG_B] = done;
  assign sys_commit[SYS_PK_A]  = done && cfg_ready;
  assign sys_commit[SYS_PK_B]  = done && cfg_ready;
  assign sys_clr[SYS_CFG_A]    = 1'b0;
  assign sys_clr[SYS_CFG_B]    = 1'b0;
  assign sys_clr[SYS_PK_A]     = clr_cmd;
  assign sys_clr[SYS_PK_B]     = clr_cmd;

  rtc_shadow_bank #(.N_WORDS(SYS_WORDS), .WORD_W(DATA_W)) u_sys (
    .clk_i (clk_i), .rst_ni (rst_ni), .wr_i ({SYS_WORDS{bus_wr}} & sys_hit),
    .commit_i (sys_commit), .clr_i (sys_clr), .wdata_i (wdata_i),
    .shadow_o (sys_sh), .live_o (sys_lv)
  );

  // protection word and unlock sequence
  logic [DATA_W-1:0] prot_q;
  logic              prot_pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q      <= '0;
      prot_pend_q <= 1'b0;
    end else if (bus_wr && addr_i == A_PROT) begin
      prot_q      <= wdata_i;
      prot_pend_q <= 1'b1;
    end else if (done) begin
      prot_pend_q <= 1'b0;
    end
  end

  rtc_unlock_seq #(.DATA_W(DATA_W)) u_unlock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (done),
    .pend_i (prot_pend_q),
    .val_i  (prot_q),
    .open_o (open)
  );

  // time validity
  logic time_dirty_q, time_valid_q, reload_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_dirty_q <= 1'b0;
      time_valid_q <= 1'b0;
      reload_q     <= 1'b0;
    end else begin
      reload_q <= ctrl_ok && wdata_i[BIT_RELOAD];
      if (|time_wr)  time_dirty_q <= 1'b1;
      else if (done) time_dirty_q <= 1'b0;
      if (clr_cmd)                   time_valid_q <= 1'b0;
      else if (done && time_dirty_q) time_valid_q <= 1'b1;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (bus_rd) begin
      if (addr_i == A_CTRL) begin
        rdata_o[BIT_BUSY]  = busy_o;
        rdata_o[BIT_OPEN]  = open;
        rdata_o[BIT_VALID] = time_valid_q;
        rdata_o[BIT_LOST]  = !key_ok;
        rdata_o[BIT_RUN]   = key_ok && cfg_ready;
      end
      if (addr_i == A_IRQ) rdata_o = irq_sh[0];
      for (int k = 0; k < N_TIME; k++)
        if (time_hit[k]) rdata_o = time_sh[k];
      for (int k = 0; k < N_ALARM; k++)
        if (alm_hit[k]) rdata_o = alm_sh[k];
      for (int k = 0; k < int'(SYS_WORDS); k++)
        if (sys_hit[k]) rdata_o = sys_sh[k];
    end
  end

  assign live_time_o   = time_lv;
  assign live_alarm_o  = alm_lv;
  assign live_irq_en_o = irq_lv[0];
  assign unlocked_o    = open;
  assign core_run_o    = key_ok && cfg_ready;
  assign pwr_lost_o    = !key_ok;
  assign time_valid_o  = time_valid_q;
  assign reload_o      = reload_q;
endmodule

// File: rtl/rtc_regif_chk.sv
module rtc_regif_chk #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned N_TIME     = 6,
  parameter int unsigned N_ALARM    = 6,
  parameter int unsigned COMMIT_CYC = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      req_i,
  input logic                      we_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DATA_W-1:0]         wdata_i,
  input logic [N_TIME*DATA_W-1:0]  live_time_o,
  input logic [N_ALARM*DATA_W-1:0] live_alarm_o,
  input logic                      busy_o,
  input logic                      unlocked_o,
  input logic                      core_run_o,
  input logic                      time_valid_o,
  input logic                      reload_o
);
  localparam int unsigned RUN_W = $clog2(COMMIT_CYC + 2) + 1;
  logic [RUN_W-1:0] busy_run;
  logic unused_ok;
  assign unused_ok = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             busy_run <= '0;
    else if (!busy_o)        busy_run <= '0;
    else if (busy_run != '1) busy_run <= busy_run + 1'b1;
  end

  p_live_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(busy_o) |-> ($stable(live_time_o) && $stable(live_alarm_o)));

  p_busy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i && we_i && addr_i == ADDR_W'(8'h78) && wdata_i[0]));

  p_busy_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_run <= RUN_W'(COMMIT_CYC));

  p_busy_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_run == RUN_W'(COMMIT_CYC));

  p_reload_key_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_o |-> $past(req_i && we_i && addr_i == ADDR_W'(8'h00) &&
                       wdata_i[DATA_W-1:DATA_W-8] == 8'h43 && wdata_i[5]));

  p_unlock_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlocked_o) |-> $fell(busy_o));

  p_unlock_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(unlocked_o));

  p_run_commit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_run_o) |-> $fell(busy_o));

  p_valid_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(time_valid_o) |-> $fell(busy_o));
endmodule

bind rtc_regif rtc_regif_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_TIME(N_TIME),
  .N_ALARM(N_ALARM), .COMMIT_CYC(COMMIT_CYC)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .live_time_o  (live_time_o),
  .live_alarm_o (live_alarm_o),
  .busy_o       (busy_o),
  .unlocked_o   (unlocked_o),
  .core_run_o   (core_run_o),
  .time_valid_o (time_valid_o),
  .reload_o     (reload_o)
);

// File: tb/rtc_regif_test.sv
module rtc_regif_test;
  localparam logic [7:0] A_CTRL = 8'h00, A_IRQ = 8'h08, A_TIME0 = 8'h20,
                         A_PKA = 8'h4C, A_PKB = 8'h50, A_CFGA = 8'h5C,
                         A_CFGB = 8'h60, A_PROT = 8'h70, A_TRIG = 8'h78,
                         A_ALM0 = 8'h80;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, live_irq;
  logic [95:0] live_time, live_alarm;
  logic        busy, unlocked, core_run, pwr_lost, time_valid, reload;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rtc_regif uut (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .live_time_o (live_time),
    .live_alarm_o (live_alarm), .live_irq_en_o (live_irq), .busy_o (busy),
    .unlocked_o (unlocked), .core_run_o (core_run), .pwr_lost_o (pwr_lost),
    .time_valid_o (time_valid), .reload_o (reload)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic commit();
    wr(A_TRIG, 16'h0001);
    while (busy) @(negedge clk);
  endtask

  function automatic logic [15:0] tw(input int k);
    return live_time[k*16 +: 16];
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    rd(A_CTRL, d);  chk("R10 ctrl after reset", d, 16'h0002);
    chk("R8 pwr_lost after reset", pwr_lost, 1'b1);
    chk("R10 busy idle", busy, 1'b0);
    chk("R10 locked", unlocked, 1'b0);
    chk("R10 live time zero", live_time[31:0], 32'h0);
    rd(A_TRIG, d);  chk("R10 trigger reads zero", d, 16'h0);
  endtask

  task automatic t_locked();
    logic [15:0] d;
    wr(A_TIME0, 16'h1234);
    wr(A_ALM0, 16'h0055);
    wr(A_IRQ, 16'h0003);
    rd(A_TIME0, d); chk("R6 locked time write dropped", d, 16'h0);
    rd(A_ALM0, d);  chk("R6 locked alarm write dropped", d, 16'h0);
    rd(A_IRQ, d);   chk("R6 locked irq write dropped", d, 16'h0);
    commit();
    chk("R6 live time after locked commit", tw(0), 16'h0);
    chk("R6 live irq after locked commit", live_irq, 16'h0);
    chk("R9 no valid from dropped writes", time_valid, 1'b0);
  endtask

  task automatic t_ctrl();
    wr(A_CTRL, 16'h0020);
    chk("R3 reload without key", reload, 1'b0);
    wr(A_CTRL, 16'h4220);
    chk("R3 reload with wrong key", reload, 1'b0);
    wr(A_CTRL, 16'h4320);
    chk("R3 reload pulse", reload, 1'b1);
    @(negedge clk);
    chk("R3 reload one cycle", reload, 1'b0);
  endtask

  task automatic t_keys();
    logic [15:0] d;
    wr(A_CFGA, 16'h4848);
    wr(A_CFGB, 16'h0048);
    wr(A_PKA, 16'hA357);
    wr(A_PKB, 16'h67D2);
    commit();
    chk("R7 keys not taken with config in same commit", core_run, 1'b0);
    chk("R8 still lost", pwr_lost, 1'b1);
    commit();
    chk("R7 run after second commit", core_run, 1'b1);
    chk("R8 lost clears", pwr_lost, 1'b0);
    rd(A_CTRL, d);  chk("R7 ctrl run bit", d, 16'h0001);
    wr(A_CTRL, 16'h4210);
    chk("R3 clear with wrong key ignored", core_run, 1'b1);
  endtask

  task automatic t_bad_unlock();
    wr(A_PROT, 16'h586A); commit();
    chk("R5 second word first stays locked", unlocked, 1'b0);
    wr(A_PROT, 16'h9136); commit();
    wr(A_PROT, 16'h1111); commit();
    wr(A_PROT, 16'h586A); commit();
    chk("R5 wrong middle value resets", unlocked, 1'b0);
    wr(A_PROT, 16'h9136);
    wr(A_PROT, 16'h586A); commit();
    chk("R4 no commit between steps", unlocked, 1'b0);
  endtask

  task automatic t_unlock();
    logic [15:0] d;
    wr(A_PROT, 16'h9136); commit();
    chk("R4 half sequence locked", unlocked, 1'b0);
    wr(A_PROT, 16'h586A); commit();
    chk("R4 unlocked", unlocked, 1'b1);
    rd(A_CTRL, d);  chk("R4 ctrl unlocked bit", d, 16'h0009);
    rd(A_PROT, d);  chk("R10 protection reads zero", d, 16'h0);
  endtask

  task automatic t_commit();
    logic [15:0] d;
    for (int k = 0; k < 6; k++) wr(A_TIME0 + 8'(4*k), 16'h0100 + 16'(k));
    for (int k = 0; k < 6; k++) chk("R1 live held before trigger", tw(k), 16'h0);
    rd(A_TIME0 + 8'd20, d); chk("R6 shadow read back", d, 16'h0105);
    chk("R9 not valid before commit", time_valid, 1'b0);
    commit();
    for (int k = 0; k < 6; k++) chk("R1 live after commit", tw(k), 16'h0100 + 16'(k));
    chk("R9 valid after time commit", time_valid, 1'b1);
    rd(A_CTRL, d);  chk("R9 ctrl bits", d, 16'h000D);
  endtask

  task automatic t_busy();
    wr(A_ALM0, 16'h00AA);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = A_TRIG; wdata = 16'h0001;
    @(negedge clk);
    chk("R2 busy cycle 1", busy, 1'b1);
    @(negedge clk);
    we = 1'b0; addr = A_CTRL;
    #1 chk("R2 ctrl busy bit", rdata[6], 1'b1);
    req = 1'b0;
    @(negedge clk); chk("R2 busy cycle 3", busy, 1'b1);
    @(negedge clk); chk("R2 busy cycle 4", busy, 1'b1);
    chk("R2 live not yet updated", live_alarm[15:0], 16'h0);
    @(negedge clk); chk("R2 busy ends after 4, retrigger ignored", busy, 1'b0);
    chk("R2 live updated at end", live_alarm[15:0], 16'h00AA);
  endtask

  task automatic t_same_cycle();
    logic [15:0] d;
    wr(A_TIME0, 16'h0300);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = A_TRIG; wdata = 16'h0001;
    @(negedge clk); req = 1'b0; we = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = A_TIME0; wdata = 16'h0400;
    @(negedge clk); req = 1'b0; we = 1'b0;
    chk("R2 commit done", busy, 1'b0);
    chk("R1 live takes old value on collision", tw(0), 16'h0300);
    rd(A_TIME0, d); chk("R1 shadow keeps new value", d, 16'h0400);
    commit();
    chk("R1 new value on next commit", tw(0), 16'h0400);
  endtask

  task automatic t_clear();
    logic [15:0] d;
    wr(A_CTRL, 16'h4310);
    chk("R3 clear drops run", core_run, 1'b0);
    chk("R8 lost after key clear", pwr_lost, 1'b1);
    chk("R3 clear drops valid", time_valid, 1'b0);
    rd(A_PKA, d);   chk("R3 key shadow cleared", d, 16'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_ctrl();
    t_keys();
    t_bad_unlock();
    t_unlock();
    t_commit();
    t_busy();
    t_same_cycle();
    t_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule